// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt

This block watches a running BCD calendar and raises an alarm when the calendar reaches a programmed month, date, hour, minute and second. An external timekeeping counter supplies the current time as BCD bytes, together with a one-cycle strobe that marks the start of each new second. When every compared field equals the stored alarm time on that strobe, the block latches an alarm flag. If the alarm-enable bit is also set, the block pulls an active-low interrupt line low. The line stays low as long as both the flag and the enable are set.

Software reaches the block through a byte-wide register port with an address, write data, a write strobe and combinational read data. Five alarm registers hold the target time. The month byte also carries the alarm enable and an independent square-wave enable bit. The hours byte also carries a halt-update bit. A flags register reports three things: the alarm flag, a sticky oscillator-failure flag, and the live battery-low input.

Flags are cleared by writing 0 to their bit. Writing 1 to a flag bit leaves it as it is, so software clears one flag with a read-modify-write.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset all five alarm registers read 0x00. The alarm flag and the oscillator-failure flag read 0, and `alarm_irq_n` is 1.
- R2: Alarm registers keep only their defined bits, and the other bits read 0. The layout is:
  - 0x0A: bit 7 alarm enable, bit 6 square-wave enable, bits 5:0 month.
  - 0x0B: bits 5:0 date.
  - 0x0C: bit 6 halt-update, bits 5:0 hour.
  - 0x0D: bits 6:0 minutes.
  - 0x0E: bits 6:0 seconds.
- R3: The alarm enable and square-wave enable in 0x0A are stored independently of the month field. The comparison uses only alarm month bits 5:0 and hour and date bits 5:0. Calendar-input bits 7:6 of month, date and hour, and bit 7 of minutes and seconds, are ignored.
- R4: The alarm flag (0x0F bit 6) sets only on an edge where `sec_tick` is 1 and all five compared fields equal the current time. A difference in any single field, or a low `sec_tick`, leaves the flag at 0.
- R5: The alarm flag sets on a match whether or not the alarm enable is 1.
- R6: The alarm flag is cleared only by a write to 0x0F with bit 6 equal to 0. Writing 1 leaves it unchanged. A match on the same edge as a clearing write leaves the flag set.
- R7: The oscillator-failure flag (0x0F bit 2) sets while `osc_fail` is 1 and stays set after `osc_fail` falls. It clears with the same write-0 rule as R6.
- R8: 0x0F bit 4 always reflects the `batt_low` input, and writes do not affect it. All other bits of 0x0F read 0.
- R9: `alarm_irq_n` is 0 exactly when the alarm flag and the alarm enable are both 1. Clearing the enable releases the line without clearing the flag.
- R10: The halt-update bit sets when `halt_set` is 1 and otherwise takes bit 6 of each write to 0x0C. `halt_set` wins over a write on the same edge.
- R11: Addresses outside 0x0A–0x0F read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cur_month | input | 8 | Current month, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_sec | input | 8 | Current seconds, BCD |
| sec_tick | input | 1 | One-cycle strobe at the start of each second |
| osc_fail | input | 1 | Oscillator failure indication |
| batt_low | input | 1 | Battery-low indication |
| halt_set | input | 1 | Sets the halt-update bit |
| alarm_irq_n | output | 1 | Active-low level interrupt |

## Verification
The seconds input is swept through all sixty BCD values with the other fields matching. This shows that exactly one second value sets the flag. Each of the five fields is then put one value off the target in turn, which separates a full comparison from one that ignores a field. The calendar bytes are also driven with their high bits set, which separates a masked comparison from an unmasked one. The enable is toggled and the flags are written with 0s, with 1s, and on the same edge as a match; these cases separate the flag from the interrupt and show the set-over-clear priority.

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int AW = 5,
  parameter int BASE = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [7:0]    cur_month,
  input  logic [7:0]    cur_date,
  input  logic [7:0]    cur_hour,
  input  logic [7:0]    cur_min,
  input  logic [7:0]    cur_sec,
  input  logic          sec_tick,
  input  logic          osc_fail,
  input  logic          batt_low,
  input  logic          halt_set,
  output logic          alarm_irq_n
);
  localparam logic [AW-1:0] A_MON  = AW'(BASE);
  localparam logic [AW-1:0] A_DATE = AW'(BASE + 1);
  localparam logic [AW-1:0] A_HOUR = AW'(BASE + 2);
  localparam logic [AW-1:0] A_MIN  = AW'(BASE + 3);
  localparam logic [AW-1:0] A_SEC  = AW'(BASE + 4);
  localparam logic [AW-1:0] A_FLG  = AW'(BASE + 5);
  localparam int AF_BIT = 6;
  localparam int BL_BIT = 4;
  localparam int OF_BIT = 2;

  logic       al_en, al_sqw, al_halt;
  logic [5:0] al_mon, al_date, al_hour;
  logic [6:0] al_min, al_sec;
  logic       af_q, of_q;

  wire wr_mon  = reg_wr && (reg_addr == A_MON);
  wire wr_date = reg_wr && (reg_addr == A_DATE);
  wire wr_hour = reg_wr && (reg_addr == A_HOUR);
  wire wr_min  = reg_wr && (reg_addr == A_MIN);
  wire wr_sec  = reg_wr && (reg_addr == A_SEC);
  wire wr_flg  = reg_wr && (reg_addr == A_FLG);

  wire fields_eq = (al_sec  == cur_sec[6:0])   &&
                   (al_min  == cur_min[6:0])   &&
                   (al_hour == cur_hour[5:0])  &&
                   (al_date == cur_date[5:0])  &&
                   (al_mon  == cur_month[5:0]);
  wire hit = sec_tick && fields_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_en   <= 1'b0;
      al_sqw  <= 1'b0;
      al_mon  <= '0;
      al_date <= '0;
      al_hour <= '0;
      al_min  <= '0;
      al_sec  <= '0;
    end else begin
      if (wr_mon) begin
        al_en  <= reg_wdata[7];
        al_sqw <= reg_wdata[6];
        al_mon <= reg_wdata[5:0];
      end
      if (wr_date) al_date <= reg_wdata[5:0];
      if (wr_hour) al_hour <= reg_wdata[5:0];
      if (wr_min)  al_min  <= reg_wdata[6:0];
      if (wr_sec)  al_sec  <= reg_wdata[6:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       al_halt <= 1'b0;
    else if (halt_set) al_halt <= 1'b1;
    else if (wr_hour)  al_halt <= reg_wdata[6];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_q <= 1'b0;
      of_q <= 1'b0;
    end else begin
      if (hit) af_q <= 1'b1;
      else if (wr_flg && !reg_wdata[AF_BIT]) af_q <= 1'b0;
      if (osc_fail) of_q <= 1'b1;
      else if (wr_flg && !reg_wdata[OF_BIT]) of_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    unique case (reg_addr)
      A_MON:   reg_rdata = {al_en, al_sqw, al_mon};
      A_DATE:  reg_rdata = {2'b00, al_date};
      A_HOUR:  reg_rdata = {1'b0, al_halt, al_hour};
      A_MIN:   reg_rdata = {1'b0, al_min};
      A_SEC:   reg_rdata = {1'b0, al_sec};
      A_FLG: begin
        reg_rdata[AF_BIT] = af_q;
        reg_rdata[BL_BIT] = batt_low;
        reg_rdata[OF_BIT] = of_q;
      end
      default: reg_rdata = 8'h00;
    endcase
  end

  assign alarm_irq_n = ~(af_q & al_en);
endmodule

module rtc_alarm_cmp_chk #(
  parameter int AW = 5,
  parameter int BASE = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          sec_tick,
  input logic          alarm_irq_n
);
  localparam logic [AW-1:0] A_MON = AW'(BASE);
  localparam logic [AW-1:0] A_MIN = AW'(BASE + 3);
  localparam logic [AW-1:0] A_FLG = AW'(BASE + 5);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_irq_n && !reg_wr) |=> !alarm_irq_n);

  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_irq_n) |-> $past(sec_tick || reg_wr));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_FLG && reg_rdata[6] && !reg_wr) |=>
      (reg_addr != A_FLG || reg_rdata[6]));

  // R2
  min_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MIN) |=>
      (reg_addr != A_MIN || reg_wr || reg_rdata == {1'b0, $past(reg_wdata[6:0])}));

  // R11
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < A_MON || reg_addr > A_FLG) |-> reg_rdata == 8'h00);
endmodule

bind rtc_alarm_cmp rtc_alarm_cmp_chk chk_i (.*);

// File: tb/rtc_alarm_cmp_tb.sv
module rtc_alarm_cmp_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [4:0] reg_addr = 0;
  logic       reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [7:0] cur_month = 0, cur_date = 0, cur_hour = 0, cur_min = 0, cur_sec = 0;
  logic       sec_tick = 0, osc_fail = 0, batt_low = 0, halt_set = 0;
  logic       alarm_irq_n;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_alarm_cmp dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [7:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic tick();
    sec_tick = 1;
    @(posedge clk); #1;
    sec_tick = 0;
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction

  function automatic logic [7:0] flg(input bit af, input bit bl, input bit of_f);
    return {1'b0, af, 1'b0, bl, 1'b0, of_f, 2'b00};
  endfunction

  task automatic set_cur(input logic [7:0] mo, d, h, mi, s);
    cur_month = mo; cur_date = d; cur_hour = h; cur_min = mi; cur_sec = s;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] tgt [5];
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    for (int a = 10; a < 15; a++) rd("R1", 5'(a), 8'h00);
    rd("R1", 5'h0F, 8'h00);
    chk("R1 irq", {7'b0, alarm_irq_n}, 8'h01);

    // R8 battery-low is live and unwritable; R6 writing 1s sets nothing
    batt_low = 1;
    rd("R8", 5'h0F, flg(0, 1, 0));
    wr(5'h0F, 8'hFF);
    rd("R6 write1", 5'h0F, flg(0, 1, 0));
    wr(5'h0F, 8'h00);
    rd("R8 write0", 5'h0F, flg(0, 1, 0));
    batt_low = 0;
    rd("R8 low", 5'h0F, flg(0, 0, 0));

    // R2 masks
    wr(5'h0B, 8'hFF); rd("R2 date", 5'h0B, 8'h3F);
    wr(5'h0C, 8'hFF); rd("R2 hour", 5'h0C, 8'h7F);
    wr(5'h0D, 8'hFF); rd("R2 min", 5'h0D, 8'h7F);
    wr(5'h0E, 8'hFF); rd("R2 sec", 5'h0E, 8'h7F);
    wr(5'h0A, 8'hBF); rd("R2 mon", 5'h0A, 8'hBF);
    wr(5'h0A, 8'h40); rd("R3 sqw", 5'h0A, 8'h40);

    // R10 halt-update bit
    wr(5'h0C, 8'h00); rd("R10 clr", 5'h0C, 8'h00);
    halt_set = 1; @(posedge clk); #1; halt_set = 0;
    rd("R10 set", 5'h0C, 8'h40);
    reg_addr = 5'h0C; reg_wdata = 8'h05; reg_wr = 1; halt_set = 1;
    @(posedge clk); #1; reg_wr = 0; halt_set = 0;
    rd("R10 prio", 5'h0C, 8'h45);
    wr(5'h0C, 8'h23); rd("R10 wr", 5'h0C, 8'h23);

    // R11 unmapped
    wr(5'h09, 8'hFF); wr(5'h10, 8'hFF);
    rd("R11", 5'h09, 8'h00); rd("R11", 5'h10, 8'h00); rd("R11", 5'h00, 8'h00);
    rd("R11 nochg", 5'h0C, 8'h23);

    // program alarm, enable off, square-wave on
    tgt = '{8'h12, 8'h25, 8'h23, 8'h45, 8'h37};
    wr(5'h0A, 8'h52); wr(5'h0B, tgt[1]); wr(5'h0C, tgt[2]);
    wr(5'h0D, tgt[3]); wr(5'h0E, tgt[4]);

    // R4 no tick, no flag
    set_cur(tgt[0], tgt[1], tgt[2], tgt[3], tgt[4]);
    repeat (3) @(posedge clk); #1;
    rd("R4 notick", 5'h0F, flg(0, 0, 0));

    // R4/R5 seconds sweep
    for (int v = 0; v < 60; v++) begin
      bit exp_af;
      exp_af = (bcd(v) == tgt[4]);
      cur_sec = bcd(v);
      tick();
      rd("R4 sweep", 5'h0F, flg(exp_af, 0, 0));
      chk("R5 irq", {7'b0, alarm_irq_n}, 8'h01);
      if (exp_af) begin
        wr(5'h0F, 8'h00);
        rd("R6 clr", 5'h0F, flg(0, 0, 0));
      end
    end

    // R4 single-field mismatch
    for (int f = 0; f < 5; f++) begin
      logic [7:0] c [5];
      c = tgt;
      c[f] = c[f] ^ 8'h01;
      set_cur(c[0], c[1], c[2], c[3], c[4]);
      tick();
      rd("R4 field", 5'h0F, flg(0, 0, 0));
    end

    // R3 upper calendar bits ignored
    set_cur(tgt[0] | 8'hC0, tgt[1] | 8'hC0, tgt[2] | 8'hC0, tgt[3] | 8'h80, tgt[4] | 8'h80);
    tick();
    rd("R3 mask", 5'h0F, flg(1, 0, 0));
    wr(5'h0F, 8'h00);

    // R9 interrupt
    wr(5'h0A, 8'hD2);
    rd("R3 en", 5'h0A, 8'hD2);
    chk("R9 idle", {7'b0, alarm_irq_n}, 8'h01);
    set_cur(tgt[0], tgt[1], tgt[2], tgt[3], tgt[4]);
    tick();
    chk("R9 low", {7'b0, alarm_irq_n}, 8'h00);
    wr(5'h0F, 8'h40);
    rd("R6 keep", 5'h0F, flg(1, 0, 0));
    chk("R9 keep", {7'b0, alarm_irq_n}, 8'h00);
    wr(5'h0A, 8'h52);
    chk("R9 dis", {7'b0, alarm_irq_n}, 8'h01);
    rd("R9 af", 5'h0F, flg(1, 0, 0));
    wr(5'h0A, 8'hD2);
    chk("R9 reen", {7'b0, alarm_irq_n}, 8'h00);
    wr(5'h0F, 8'h00);
    chk("R9 clr", {7'b0, alarm_irq_n}, 8'h01);
    rd("R6 cleared", 5'h0F, flg(0, 0, 0));

    // R6 set wins over clear
    reg_addr = 5'h0F; reg_wdata = 8'h00; reg_wr = 1; sec_tick = 1;
    @(posedge clk); #1; reg_wr = 0; sec_tick = 0;
    rd("R6 prio", 5'h0F, flg(1, 0, 0));

    // R7 oscillator flag
    osc_fail = 1; @(posedge clk); #1; osc_fail = 0;
    @(posedge clk); #1;
    rd("R7 sticky", 5'h0F, flg(1, 0, 1));
    wr(5'h0F, 8'h04);
    rd("R7 w1", 5'h0F, flg(0, 0, 1));
    wr(5'h0F, 8'hFB);
    rd("R7 clr", 5'h0F, flg(0, 0, 0));

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule